// File: doc/BRIEF.md
# Fuse Bank/Word Read Sequencer

This block answers fuse requests made of an operation code, a bank number and a word index. It maps the bank number onto one of three regions. The low banks hold security fuses, which are decoded but never read. The next bank holds the first one-time-programmable array, with three 32-bit words. The bank after that holds the second array, with four words. Requests that fall outside these regions, and every request other than a read, are answered at once with a status code and cause no bus traffic.

A valid read of one of the two arrays makes the sequencer master a small register bus towards that array's read-port controller. It brings the controller into a readable state through a fixed series of read-modify-write accesses, waits the strobe low time and the per-word settling time (both counted in clock cycles derived from the clock frequency), reads every word of the array in order into a local buffer, and returns the requested word. Each answer is a one-cycle `done` pulse carrying the value and a status code. A request is taken only while the sequencer is idle and not pulsing `done`.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset `done` is 0, `status` is 0, `value` is 0 and neither `bus_rd` nor `bus_wr` is asserted.
- R2: For a read (op 0) of a bank below 44, a word index of 3 or more gives status 1 (invalid argument), and any smaller index gives status 2 (not implemented), with no bus access.
- R3: A read of bank 44 with word below 3 is served from the array selected by `bus_sel`=0, and one of bank 45 with word below 4 from the array selected by `bus_sel`=1; `status` is 0 and `value` is the stored word at that index.
- R4: A read of any bank above 45, or of bank 44/45 with a word index at or beyond its word count, gives status 1 with `value` 0 and no bus access.
- R5: A served read performs, each as a read of the register then a write of the changed value with all other bits kept, in this order: clear bit 15 of the control register (offset 0x0); set bit 13 of it; set bit 8 of the pointer register (offset 0x8); set then clear bit 14 of the control register; set, clear and set bit 3 of the control register. `bus_rd` and `bus_wr` are never high together, and read data is taken in the cycle after `bus_rd`.
- R6: Bit 3 of the control register stays low for at least `ceil(STROBE_LOW_NS*CLK_MHZ/1000)` cycles between its clearing write and its setting write.
- R7: Each read of the data port (offset 0x4) comes at least `ceil(WORD_WAIT_NS*CLK_MHZ/1000)` cycles after the strobe setting write or the previous data-port read.
- R8: A served read makes exactly as many data-port reads as the selected array has words, in order, before `done`.
- R9: Program (op 1), sense (op 2) and override (op 3) requests return status 2 with `value` 0 and no bus access, whatever the bank and word.
- R10: `done` is high for exactly one cycle per answer, and a request presented while a read is in progress or while `done` is high is ignored.
- R11: A request that needs no bus access is answered with `done` in the cycle after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_op | input | 2 | 0 read, 1 program, 2 sense, 3 override |
| req_bank | input | 8 | Bank number |
| req_word | input | 8 | Word index within the bank |
| done | output | 1 | One-cycle answer pulse |
| value | output | 32 | Returned fuse word (0 unless status is 0) |
| status | output | 2 | 0 ok, 1 invalid argument, 2 not implemented / not supported |
| bus_sel | output | 1 | Selects the read-port controller of array 0 or 1 |
| bus_addr | output | 4 | Register offset: 0x0 control, 0x4 data port, 0x8 pointer |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
The bench models both read-port controllers with random contents in the unrelated register bits and a random starting read pointer, and it returns a poison word whenever the data port is read with the mode bit set, the power bit clear, the strobe low or the index past the array. A sequencer that skipped the pointer reset, wrote a constant instead of a modified value, or reordered the steps would therefore return the wrong word or leave the wrong register contents. Bank boundaries (43/44/45/46) and word indices one past each count are driven directly, where an off-by-one decode would turn an error into a bus sequence or the reverse. Strobe and settling gaps are timed against their cycle minimums, and a stray request is injected mid-read to catch a sequencer that restarts or answers twice.

// File: rtl/fuse_pkg.sv
// Package: shared types and register layout for the fuse read sequencer.
// Assumes the read-port controller decodes offsets 0x0/0x4/0x8 and the
// control/pointer bit positions below.
package fuse_pkg;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_INVAL = 2'd1,
        ST_UNSUP = 2'd2
    } fuse_status_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_SENSE = 2'd2,
        OP_OVR   = 2'd3
    } fuse_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RMW_RD,
        S_RMW_WR,
        S_STRB_WAIT,
        S_DATA_WAIT,
        S_DATA_RD,
        S_DATA_CAP,
        S_FINISH
    } seq_state_e;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_DATA = 4'h4;
    localparam logic [3:0] OFS_PTR  = 4'h8;

    localparam logic [3:0] BIT_MODE = 4'd15;
    localparam logic [3:0] BIT_RST  = 4'd14;
    localparam logic [3:0] BIT_PWR  = 4'd13;
    localparam logic [3:0] BIT_INC  = 4'd8;
    localparam logic [3:0] BIT_STRB = 4'd3;

    localparam logic [2:0] STEP_STRB_LOW = 3'd6;
    localparam logic [2:0] STEP_LAST     = 3'd7;

    typedef struct packed {
        logic [3:0] addr;
        logic [3:0] bitpos;
        logic       set;
    } rmw_step_t;

    // One entry of the fixed bring-up sequence; order is behaviour.
    function automatic rmw_step_t rmw_step(input logic [2:0] idx);
        rmw_step_t s;
        case (idx)
            3'd0:    s = '{OFS_CTRL, BIT_MODE, 1'b0};
            3'd1:    s = '{OFS_CTRL, BIT_PWR,  1'b1};
            3'd2:    s = '{OFS_PTR,  BIT_INC,  1'b1};
            3'd3:    s = '{OFS_CTRL, BIT_RST,  1'b1};
            3'd4:    s = '{OFS_CTRL, BIT_RST,  1'b0};
            3'd5:    s = '{OFS_CTRL, BIT_STRB, 1'b1};
            3'd6:    s = '{OFS_CTRL, BIT_STRB, 1'b0};
            default: s = '{OFS_CTRL, BIT_STRB, 1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fuse_bank_decode.sv
// Module: maps (op, bank, word) onto a status, and for served reads onto an
// array select and word count. Purely combinational.
// Assumes SEC_BANKS+1 fits in BANK_W bits.
module fuse_bank_decode
    import fuse_pkg::*;
#(
    parameter int SEC_BANKS = 44,
    parameter int SEC_WORDS = 3,
    parameter int A0_WORDS  = 3,
    parameter int A1_WORDS  = 4,
    parameter int BANK_W    = 8,
    parameter int WORD_W    = 8,
    parameter int CNT_W     = 3
) (
    input  logic [1:0]        op,
    input  logic [BANK_W-1:0] bank,
    input  logic [WORD_W-1:0] word,
    output logic              needs_read,
    output logic              arr_sel,
    output logic [CNT_W-1:0]  nwords,
    output fuse_status_e      status
);
    localparam logic [BANK_W-1:0] BANK_A0 = BANK_W'(SEC_BANKS);
    localparam logic [BANK_W-1:0] BANK_A1 = BANK_W'(SEC_BANKS + 1);

    // Classify the request into one of the regions.
    always_comb begin
        needs_read = 1'b0;
        arr_sel    = 1'b0;
        nwords     = CNT_W'(A0_WORDS);
        status     = ST_INVAL;
        if (op != OP_READ) begin
            status = ST_UNSUP;
        end else if (bank < BANK_A0) begin
            status = (word >= WORD_W'(SEC_WORDS)) ? ST_INVAL : ST_UNSUP;
        end else if (bank == BANK_A0) begin
            if (word < WORD_W'(A0_WORDS)) begin
                needs_read = 1'b1;
                status     = ST_OK;
            end
        end else if (bank == BANK_A1) begin
            arr_sel = 1'b1;
            nwords  = CNT_W'(A1_WORDS);
            if (word < WORD_W'(A1_WORDS)) begin
                needs_read = 1'b1;
                status     = ST_OK;
            end
        end
    end

endmodule

// File: rtl/fuse_delay_timer.sv
// Module: down-counter for enforced waits. A load pulse starts a wait of
// len cycles; expired is high whenever the count has reached zero.
module fuse_delay_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] len,
    output logic             expired
);
    logic [WIDTH-1:0] cnt_q;

    // Load or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= len;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fuse_read_seq.sv
// Module: top of the fuse read sequencer. Decodes a request, and for a
// served read drives the bring-up register sequence on the selected array's
// read-port controller, reads every word into a buffer and answers with the
// requested one. Assumes bus_rdata is valid in the cycle after bus_rd.
module fuse_read_seq
    import fuse_pkg::*;
#(
    parameter int CLK_MHZ       = 250,
    parameter int STROBE_LOW_NS = 100,
    parameter int WORD_WAIT_NS  = 100000,
    parameter int SEC_BANKS     = 44,
    parameter int SEC_WORDS     = 3,
    parameter int A0_WORDS      = 3,
    parameter int A1_WORDS      = 4,
    parameter int BANK_W        = 8,
    parameter int WORD_W        = 8,
    parameter int DATA_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [WORD_W-1:0] req_word,
    output logic              done,
    output logic [DATA_W-1:0] value,
    output logic [1:0]        status,
    output logic              bus_sel,
    output logic [3:0]        bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int MAX_WORDS = (A0_WORDS > A1_WORDS) ? A0_WORDS : A1_WORDS;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
    localparam int STRB_RAW  = (STROBE_LOW_NS * CLK_MHZ + 999) / 1000;
    localparam int WAIT_RAW  = (WORD_WAIT_NS * CLK_MHZ + 999) / 1000;
    localparam int STRB_CYC  = (STRB_RAW < 1) ? 1 : STRB_RAW;
    localparam int WAIT_CYC  = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int TMR_MAX   = (STRB_CYC > WAIT_CYC) ? STRB_CYC : WAIT_CYC;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);

    seq_state_e        state_q;
    logic [2:0]        step_q;
    logic [IDX_W-1:0]  widx_q;
    logic [IDX_W-1:0]  lat_idx_q;
    logic [CNT_W-1:0]  lat_nwords_q;
    logic              lat_sel_q;
    logic              done_q;
    fuse_status_e      status_q;
    logic [DATA_W-1:0] value_q;
    logic [DATA_W-1:0] word_buf [MAX_WORDS];

    logic              dec_needs_read;
    logic              dec_sel;
    logic [CNT_W-1:0]  dec_nwords;
    fuse_status_e      dec_status;
    logic              accept_ok;
    logic              last_word;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_len;
    logic              tmr_expired;
    rmw_step_t         cur;
    logic [DATA_W-1:0] bit_mask;

    fuse_bank_decode #(
        .SEC_BANKS (SEC_BANKS),
        .SEC_WORDS (SEC_WORDS),
        .A0_WORDS  (A0_WORDS),
        .A1_WORDS  (A1_WORDS),
        .BANK_W    (BANK_W),
        .WORD_W    (WORD_W),
        .CNT_W     (CNT_W)
    ) u_decode (
        .op         (req_op),
        .bank       (req_bank),
        .word       (req_word),
        .needs_read (dec_needs_read),
        .arr_sel    (dec_sel),
        .nwords     (dec_nwords),
        .status     (dec_status)
    );

    fuse_delay_timer #(.WIDTH(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

    // Request acceptance and end-of-array detection.
    assign accept_ok = (state_q == S_IDLE) && !done_q;
    assign last_word = ((CNT_W'(widx_q) + 1'b1) == lat_nwords_q);

    // Start a wait after the strobe-clearing write, the strobe-setting write
    // and every data capture that is not the last.
    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = TMR_W'(WAIT_CYC);
        if (state_q == S_RMW_WR && step_q == STEP_STRB_LOW) begin
            tmr_load = 1'b1;
            tmr_len  = TMR_W'(STRB_CYC);
        end else if (state_q == S_RMW_WR && step_q == STEP_LAST) begin
            tmr_load = 1'b1;
        end else if (state_q == S_DATA_CAP && !last_word) begin
            tmr_load = 1'b1;
        end
    end

    // Bus drive: current step's register, changed bit applied to read data.
    always_comb begin
        cur       = rmw_step(step_q);
        bit_mask  = DATA_W'(1) << cur.bitpos;
        bus_sel   = lat_sel_q;
        bus_rd    = (state_q == S_RMW_RD) || (state_q == S_DATA_RD);
        bus_wr    = (state_q == S_RMW_WR);
        bus_addr  = (state_q == S_DATA_RD) ? OFS_DATA : cur.addr;
        bus_wdata = cur.set ? (bus_rdata | bit_mask) : (bus_rdata & ~bit_mask);
    end

    // Word buffer: one register per array word, loaded on its capture cycle.
    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_buf[g] <= '0;
            else if (state_q == S_DATA_CAP && widx_q == IDX_W'(g))
                word_buf[g] <= bus_rdata;
        end
    end

    // Sequencer state machine and answer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            step_q       <= '0;
            widx_q       <= '0;
            lat_idx_q    <= '0;
            lat_nwords_q <= '0;
            lat_sel_q    <= 1'b0;
            done_q       <= 1'b0;
            status_q     <= ST_OK;
            value_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid && accept_ok) begin
                        if (dec_needs_read) begin
                            lat_sel_q    <= dec_sel;
                            lat_nwords_q <= dec_nwords;
                            lat_idx_q    <= req_word[IDX_W-1:0];
                            step_q       <= '0;
                            widx_q       <= '0;
                            state_q      <= S_RMW_RD;
                        end else begin
                            done_q   <= 1'b1;
                            status_q <= dec_status;
                            value_q  <= '0;
                        end
                    end
                end
                S_RMW_RD: state_q <= S_RMW_WR;
                S_RMW_WR: begin
                    if (step_q == STEP_STRB_LOW) begin
                        state_q <= S_STRB_WAIT;
                    end else if (step_q == STEP_LAST) begin
                        state_q <= S_DATA_WAIT;
                    end else begin
                        step_q  <= step_q + 1'b1;
                        state_q <= S_RMW_RD;
                    end
                end
                S_STRB_WAIT: begin
                    if (tmr_expired) begin
                        step_q  <= step_q + 1'b1;
                        state_q <= S_RMW_RD;
                    end
                end
                S_DATA_WAIT: if (tmr_expired) state_q <= S_DATA_RD;
                S_DATA_RD:   state_q <= S_DATA_CAP;
                S_DATA_CAP: begin
                    if (last_word) begin
                        state_q <= S_FINISH;
                    end else begin
                        widx_q  <= widx_q + 1'b1;
                        state_q <= S_DATA_WAIT;
                    end
                end
                S_FINISH: begin
                    done_q   <= 1'b1;
                    status_q <= ST_OK;
                    value_q  <= word_buf[lat_idx_q];
                    state_q  <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign done   = done_q;
    assign status = status_q;
    assign value  = value_q;

endmodule

// File: rtl/fuse_seq_checks.sv
// Module: property checker for the fuse read sequencer, bound to the top.
module fuse_seq_checks #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              idle_ok,
    input logic              needs_read,
    input logic              done,
    input logic [1:0]        status,
    input logic [DATA_W-1:0] value,
    input logic              bus_sel,
    input logic              bus_rd,
    input logic              bus_wr
);
    // R10: an answer pulse never lasts two cycles.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: read and write strobes are exclusive.
    p_rdwr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R9: no bus access in an answer cycle.
    p_quiet_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(bus_rd || bus_wr));

    // R11: a request needing no bus access is answered on the next cycle.
    p_err_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idle_ok && !needs_read) |=> (done && status != 2'd0));

    // R4: an error answer carries a zero value.
    p_err_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd0) |-> (value == '0));

    // R2: only the three defined status codes appear.
    p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd3));

    // R3: the array select holds across back-to-back accesses.
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && $past(bus_rd || bus_wr)) |-> $stable(bus_sel));

endmodule

bind fuse_read_seq fuse_seq_checks #(.DATA_W(DATA_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .idle_ok    (accept_ok),
    .needs_read (dec_needs_read),
    .done       (done),
    .status     (status),
    .value      (value),
    .bus_sel    (bus_sel),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr)
);

// File: tb/tb_fuse_read_seq.sv
// Bench: models both read-port controllers, drives directed and seeded
// random requests and compares answers and bus behaviour with expectations.
module tb_fuse_read_seq;
    localparam int CLK_MHZ  = 250;
    localparam int STRB_NS  = 100;
    localparam int WAIT_NS  = 400;
    localparam int STRB_MIN = (STRB_NS * CLK_MHZ + 999) / 1000;
    localparam int WAIT_MIN = (WAIT_NS * CLK_MHZ + 999) / 1000;
    localparam logic [31:0] POISON = 32'hBAD0_BAD0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_bank = '0;
    logic [7:0]  req_word = '0;
    logic        done;
    logic [31:0] value;
    logic [1:0]  status;
    logic        bus_sel;
    logic [3:0]  bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int mchecks = 0;
    int mfails  = 0;
    longint cyc = 0;

    logic [31:0] fuse_mem [2][4];
    logic [31:0] init_ctrl [2];
    logic [31:0] init_ptr  [2];
    int          init_idx  [2];
    logic        arm_model = 1'b0;

    logic [31:0] m_ctrl [2];
    logic [31:0] m_ptr  [2];
    int          m_idx  [2];
    int          data_reads = 0;
    int          bus_acc = 0;
    longint      t_low = 0;
    longint      t_ref = 0;
    logic        low_seen = 1'b0;

    always #2 clk = ~clk;

    fuse_read_seq #(
        .CLK_MHZ(CLK_MHZ), .STROBE_LOW_NS(STRB_NS), .WORD_WAIT_NS(WAIT_NS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_word(req_word), .done(done), .value(value),
        .status(status), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic int arr_words(input int sel);
        return (sel == 0) ? 3 : 4;
    endfunction

    // Model check: counted separately from the procedural checks.
    task automatic mcheck(input bit ok, input string req, input longint act, input longint exp);
        mchecks++;
        if (!ok) begin
            mfails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Read-port controller model for both arrays.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (arm_model) begin
                for (int i = 0; i < 2; i++) begin
                    m_ctrl[i] <= init_ctrl[i];
                    m_ptr[i]  <= init_ptr[i];
                    m_idx[i]  <= init_idx[i];
                end
                data_reads <= 0;
                bus_acc    <= 0;
                low_seen   <= 1'b0;
                t_ref      <= cyc;
            end
            if (bus_rd || bus_wr) bus_acc <= bus_acc + 1;
            if (bus_wr) begin
                if (bus_addr == 4'h0) begin
                    if (m_ctrl[bus_sel][3] && !bus_wdata[3]) begin
                        t_low    <= cyc;
                        low_seen <= 1'b1;
                    end
                    if (!m_ctrl[bus_sel][3] && bus_wdata[3] && low_seen) begin
                        mcheck(cyc - t_low >= STRB_MIN, "R6 strobe low cycles", cyc - t_low, STRB_MIN);
                        t_ref <= cyc;
                    end
                    m_ctrl[bus_sel] <= bus_wdata;
                    if (bus_wdata[14]) m_idx[bus_sel] <= 0;
                end else if (bus_addr == 4'h8) begin
                    m_ptr[bus_sel] <= bus_wdata;
                end else begin
                    mcheck(1'b0, "R5 write offset", bus_addr, 0);
                end
            end
            if (bus_rd) begin
                if (bus_addr == 4'h0) bus_rdata <= m_ctrl[bus_sel];
                else if (bus_addr == 4'h8) bus_rdata <= m_ptr[bus_sel];
                else if (bus_addr == 4'h4) begin
                    mcheck(cyc - t_ref >= WAIT_MIN, "R7 data read wait", cyc - t_ref, WAIT_MIN);
                    t_ref <= cyc;
                    if (!m_ctrl[bus_sel][15] && m_ctrl[bus_sel][13] && m_ctrl[bus_sel][3]
                        && m_idx[bus_sel] < arr_words(int'(bus_sel)))
                        bus_rdata <= fuse_mem[bus_sel][m_idx[bus_sel]];
                    else
                        bus_rdata <= POISON;
                    if (m_ptr[bus_sel][8]) m_idx[bus_sel] <= m_idx[bus_sel] + 1;
                    data_reads <= data_reads + 1;
                end else begin
                    mcheck(1'b0, "R5 read offset", bus_addr, 0);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_status(input int op, input int bank, input int word);
        if (op != 0) return 2'd2;
        if (bank < 44) return (word >= 3) ? 2'd1 : 2'd2;
        if (bank == 44) return (word < 3) ? 2'd0 : 2'd1;
        if (bank == 45) return (word < 4) ? 2'd0 : 2'd1;
        return 2'd1;
    endfunction

    // One request with full checking of the answer and the model's state.
    task automatic run_req(input int op, input int bank, input int word, input bit inject);
        logic [1:0]  es;
        int          sel;
        int          n;
        logic [31:0] exp_ctrl;
        for (int i = 0; i < 2; i++) begin
            init_ctrl[i] = ($urandom | 32'h0000_8000) & ~32'h0000_6000;
            init_ptr[i]  = $urandom & ~32'h0000_0100;
            init_idx[i]  = int'($urandom % 4);
        end
        es  = exp_status(op, bank, word);
        sel = bank - 44;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_bank = 8'(bank); req_word = 8'(word);
        arm_model = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; arm_model = 1'b0;
        n = 1;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            if (inject && n == 40) begin
                req_valid = 1'b1; req_op = 2'd0; req_bank = 8'd200; req_word = 8'd0;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        check(done == 1'b1, "R10 answer arrives", done, 1);
        check(status == es, $sformatf("R2/R3/R4/R9 status op%0d bank%0d word%0d", op, bank, word), status, es);
        if (es == 2'd0) begin
            check(value == fuse_mem[sel][word], $sformatf("R3 value bank%0d word%0d", bank, word), value, fuse_mem[sel][word]);
            check(data_reads == arr_words(sel), "R8 data reads", data_reads, arr_words(sel));
            exp_ctrl = (init_ctrl[sel] & ~32'h0000_C000) | 32'h0000_2008;
            check(m_ctrl[sel] == exp_ctrl, "R5 control after sequence", m_ctrl[sel], exp_ctrl);
            check(m_ptr[sel] == (init_ptr[sel] | 32'h100), "R5 pointer after sequence", m_ptr[sel], init_ptr[sel] | 32'h100);
            check(m_ctrl[1-sel] == init_ctrl[1-sel], "R3 other array untouched", m_ctrl[1-sel], init_ctrl[1-sel]);
        end else begin
            check(value == 32'd0, "R4 error value zero", value, 0);
            check(n == 1, "R11 error latency", n, 1);
            check(bus_acc == 0, "R9 no bus access", bus_acc, 0);
        end
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mchecks + 1, fails + mfails);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = int'($urandom(32'd20240611));
        for (int a = 0; a < 2; a++)
            for (int w = 0; w < 4; w++)
                fuse_mem[a][w] = $urandom;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && status == 2'd0 && value == 32'd0, "R1 reset outputs", {done, status}, 0);
        check(!bus_rd && !bus_wr, "R1 reset bus idle", {bus_rd, bus_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && !bus_rd && !bus_wr, "R1 idle after reset", {done, bus_rd, bus_wr}, 0);

        run_req(0, 43, 2, 1'b0);
        run_req(0, 43, 3, 1'b0);
        run_req(0, 0, 0, 1'b0);
        run_req(0, 44, 0, 1'b0);
        run_req(0, 44, 2, 1'b0);
        run_req(0, 44, 3, 1'b0);
        run_req(0, 45, 3, 1'b0);
        run_req(0, 45, 0, 1'b0);
        run_req(0, 45, 4, 1'b0);
        run_req(0, 46, 0, 1'b0);
        run_req(0, 255, 0, 1'b0);
        run_req(1, 44, 0, 1'b0);
        run_req(2, 45, 1, 1'b0);
        run_req(3, 10, 9, 1'b0);
        run_req(0, 45, 2, 1'b1);
        run_req(0, 44, 1, 1'b1);

        for (int k = 0; k < 60; k++) begin
            int op, bank, word, pick;
            op   = ($urandom % 5 == 0) ? int'(1 + $urandom % 3) : 0;
            pick = int'($urandom % 4);
            bank = (pick == 0) ? int'($urandom % 44) :
                   (pick == 1) ? 44 : (pick == 2) ? 45 : int'(46 + $urandom % 210);
            word = int'($urandom % 6);
            run_req(op, bank, word, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mchecks, fails + mfails);
        $finish;
    end

endmodule